// File: doc/BRIEF.md
# Stereo Sample Delay Line with Mute

This block delays a stereo pair of 24-bit audio samples by a programmable number of sample periods, set separately for the left and the right channel, anywhere from 0 to 8191 samples. A sample strobe marks each new sample pair. On that strobe both inputs are written into a circular buffer, one buffer per channel, and each channel's output register is loaded with the sample taken the programmed number of strobes earlier. At 48 kHz the longest setting is about 170.65 ms, which is enough to line audio up with video that is slow to process.

One packed control byte drives the block. Its top two bits mute either channel or both. A muted channel outputs zero, but its buffer keeps recording. The lowest two bits carry a serial-format code. The block does not interpret that code; it only exports it, except for code 11, which selects bypass. In bypass every sample goes straight through with no delay.

The delay values and the control byte are taken at each strobe. A new setting therefore applies from the first strobe that sees it. Buffer slots that have not been written since reset read as zero.

Top module: `stereo_delay_line`

## Requirements
- R1: `outValid` is high for exactly the one clock after each clock edge at which `sampleStrobe` is high. `leftOut` and `rightOut` are updated only on a strobe and hold their value between strobes.
- R2: With a delay d from 1 to 8191 and d or more strobes since reset, the channel output after strobe n equals that channel's input from strobe n-d.
- R3: With a delay of 0, the output after a strobe equals the input presented at that same strobe.
- R4: The left channel uses `leftDelay` and the right channel uses `rightDelay`. Two different values give two different, independent delays.
- R5: If the delay d is larger than the number of strobes since reset, the channel outputs zero.
- R6: `ctrlByte[6]` = 1 mutes the left channel and `ctrlByte[7]` = 1 mutes the right channel. As a pair, bits [7:6] mean 00 none muted, 01 left muted, 10 right muted, 11 both muted. A muted channel outputs zero. Bits [5:2] have no effect.
- R7: A muted channel keeps writing its input into its buffer. After unmuting, delayed outputs return samples that were taken while the channel was muted.
- R8: `ctrlByte[1:0]` = 11 selects bypass. Each unmuted channel then outputs its current input, whatever its programmed delay.
- R9: `fmtOut` equals `ctrlByte[1:0]` combinationally. The codes are 00 I2S, 01 right-justified, 10 left-justified, 11 bypass.
- R10: The delay values presented at a strobe are the ones used for that strobe. A change takes effect at the next strobe.
- R11: While `rstN` is low, `leftOut`, `rightOut` and `outValid` are zero.
- R12: The buffer wraps modulo 8192 entries. The maximum delay of 8191 stays correct once more than 8192 strobes have occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | One-cycle pulse that marks a new sample pair |
| leftIn | input | 24 | Left input sample |
| rightIn | input | 24 | Right input sample |
| ctrlByte | input | 8 | Packed control: [7:6] mute, [1:0] format or bypass |
| leftDelay | input | 13 | Left delay in samples |
| rightDelay | input | 13 | Right delay in samples |
| leftOut | output | 24 | Delayed left sample |
| rightOut | output | 24 | Delayed right sample |
| outValid | output | 1 | High the clock after a strobe |
| fmtOut | output | 2 | Decoded serial-format code |

## Verification
Every sample result falls due exactly one clock after the strobe edge. The bench raises `sampleStrobe` at a falling edge and samples `outValid`, `leftOut` and `rightOut` at the very next falling edge, comparing them with a model that indexes a bench-side history of every input pair. After idle cycles without a strobe, the bench expects `outValid` low and both outputs unchanged. `fmtOut` has no latency, so it is checked 1 ns after `ctrlByte` changes.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    FMT_I2S    = 2'b00,
    FMT_RJ     = 2'b01,
    FMT_LJ     = 2'b10,
    FMT_BYPASS = 2'b11
  } fmtE;

  typedef struct packed {
    logic              wrEn;
    logic              bypass;
    logic [NUM_CH-1:0] mute;   // [0] left, [1] right
  } dlCtrlT;
endpackage

// File: rtl/sdl_control.sv
module sdl_control
  import sdl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleStrobe,
  input  logic [7:0] ctrlByte,
  output dlCtrlT     ctl,
  output logic [1:0] fmtOut,
  output logic       outValid
);
  fmtE fmtSel;
  logic unusedCtrl;

  assign fmtSel     = fmtE'(ctrlByte[1:0]);
  assign unusedCtrl = ^ctrlByte[5:2];
  assign fmtOut     = fmtSel;

  always_comb begin
    ctl.wrEn    = sampleStrobe;
    ctl.bypass  = (fmtSel == FMT_BYPASS);
    ctl.mute[0] = ctrlByte[6];
    ctl.mute[1] = ctrlByte[7];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= sampleStrobe;
  end
endmodule

// File: rtl/sdl_channel.sv
module sdl_channel #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W:0]   fill,
  input  logic [ADDR_W-1:0] delay,
  input  logic              bypass,
  input  logic              mute,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdAddr;
  logic              passThru;
  logic              present;

  assign rdAddr   = wrAddr - delay;          // modulo DEPTH
  assign passThru = bypass || (delay == '0);
  assign present  = ({1'b0, delay} <= fill);

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= dIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOut <= '0;
    end else if (wrEn) begin
      if (mute)          dOut <= '0;
      else if (passThru) dOut <= dIn;
      else if (present)  dOut <= mem[rdAddr];
      else               dOut <= '0;
    end
  end
endmodule

// File: rtl/sdl_datapath.sv
module sdl_datapath
  import sdl_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 13
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dlCtrlT                        ctl,
  input  logic [NUM_CH-1:0][DATA_W-1:0] dataIn,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] delayIn,
  output logic [NUM_CH-1:0][DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(DEPTH);

  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W:0]   fill;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      fill  <= '0;
    end else if (ctl.wrEn) begin
      wrPtr <= wrPtr + 1'b1;
      if (fill != FULL) fill <= fill + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sdl_channel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chan_i (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (ctl.wrEn),
      .wrAddr(wrPtr),
      .fill  (fill),
      .delay (delayIn[c]),
      .bypass(ctl.bypass),
      .mute  (ctl.mute[c]),
      .dIn   (dataIn[c]),
      .dOut  (dataOut[c])
    );
  end
endmodule

// File: rtl/stereo_delay_line.sv
module stereo_delay_line
  import sdl_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStrobe,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  input  logic [7:0]        ctrlByte,
  input  logic [ADDR_W-1:0] leftDelay,
  input  logic [ADDR_W-1:0] rightDelay,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut,
  output logic              outValid,
  output logic [1:0]        fmtOut
);
  dlCtrlT ctl;
  logic [NUM_CH-1:0][DATA_W-1:0] dataIn;
  logic [NUM_CH-1:0][DATA_W-1:0] dataOut;
  logic [NUM_CH-1:0][ADDR_W-1:0] delayIn;

  assign dataIn[0]  = leftIn;
  assign dataIn[1]  = rightIn;
  assign delayIn[0] = leftDelay;
  assign delayIn[1] = rightDelay;
  assign leftOut    = dataOut[0];
  assign rightOut   = dataOut[1];

  sdl_control ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .sampleStrobe(sampleStrobe),
    .ctrlByte    (ctrlByte),
    .ctl         (ctl),
    .fmtOut      (fmtOut),
    .outValid    (outValid)
  );

  sdl_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) data_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .dataIn (dataIn),
    .delayIn(delayIn),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleStrobe,
  input logic [DATA_W-1:0] leftIn,
  input logic [DATA_W-1:0] rightIn,
  input logic [7:0]        ctrlByte,
  input logic [ADDR_W-1:0] leftDelay,
  input logic [ADDR_W-1:0] rightDelay,
  input logic [DATA_W-1:0] leftOut,
  input logic [DATA_W-1:0] rightOut,
  input logic              outValid,
  input logic [1:0]        fmtOut
);
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> outValid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> !outValid); // R1
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> ($stable(leftOut) && $stable(rightOut))); // R1
  AST_MUTE_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && ctrlByte[6]) |=> (leftOut == '0)); // R6
  AST_MUTE_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && ctrlByte[7]) |=> (rightOut == '0)); // R6
  AST_ZERO_DELAY_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && leftDelay == '0 && !ctrlByte[6]) |=> (leftOut == $past(leftIn))); // R3
  AST_ZERO_DELAY_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && rightDelay == '0 && !ctrlByte[7]) |=> (rightOut == $past(rightIn))); // R3
  AST_BYPASS_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && ctrlByte[1:0] == 2'b11 && !ctrlByte[6]) |=> (leftOut == $past(leftIn))); // R8
  AST_BYPASS_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && ctrlByte[1:0] == 2'b11 && !ctrlByte[7]) |=> (rightOut == $past(rightIn))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (leftOut == '0 && rightOut == '0 && !outValid)); // R11
endmodule

bind stereo_delay_line sdl_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/stereo_delay_line_tb_top.sv
`timescale 1ns/1ps
module stereo_delay_line_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic [7:0]  ctrlByte = '0;
  logic [12:0] leftDelay = '0, rightDelay = '0;
  logic [23:0] leftOut, rightOut;
  logic        outValid;
  logic [1:0]  fmtOut;

  int checks = 0;
  int errors = 0;
  int n = 0;
  logic [23:0] histL [16384];
  logic [23:0] histR [16384];

  always #2.5 clk = ~clk;

  stereo_delay_line dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s n=%0d got %0h expected %0h", tag, n, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input bit isRight, input logic [7:0] c, input logic [12:0] d);
    logic mute;
    mute = isRight ? c[7] : c[6];
    if (mute) return '0;
    if (c[1:0] == 2'b11 || d == 0) return isRight ? histR[n] : histL[n];
    if (int'(d) > n) return '0;
    return isRight ? histR[n - int'(d)] : histL[n - int'(d)];
  endfunction

  function automatic string pickTag(input bit isRight, input logic [7:0] c, input logic [12:0] d, input string normTag);
    if (isRight ? c[7] : c[6]) return "R6";
    if (c[1:0] == 2'b11) return "R8";
    if (d == 0) return "R3";
    if (int'(d) > n) return "R5";
    return normTag;
  endfunction

  task automatic doSample(input logic [23:0] l, input logic [23:0] r, input logic [7:0] c,
                          input logic [12:0] dl, input logic [12:0] dr, input string normTag);
    logic [23:0] expL, expR;
    string tl, tr;
    leftIn = l; rightIn = r; ctrlByte = c; leftDelay = dl; rightDelay = dr;
    sampleStrobe = 1'b1;
    histL[n] = l; histR[n] = r;
    expL = model(1'b0, c, dl); expR = model(1'b1, c, dr);
    tl = pickTag(1'b0, c, dl, normTag); tr = pickTag(1'b1, c, dr, normTag);
    @(negedge clk);
    sampleStrobe = 1'b0;
    check("R1", {31'd0, outValid}, 32'd1);
    check(tl, {8'd0, leftOut}, {8'd0, expL});
    check(tr, {8'd0, rightOut}, {8'd0, expR});
    n++;
  endtask

  task automatic idleCheck();
    logic [23:0] pl, pr;
    pl = leftOut; pr = rightOut;
    leftIn = $urandom; rightIn = $urandom;
    @(negedge clk);
    check("R1", {31'd0, outValid}, 32'd0);
    check("R1", {8'd0, leftOut}, {8'd0, pl});
    check("R1", {8'd0, rightOut}, {8'd0, pr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R11", {31'd0, outValid}, 32'd0);
    check("R11", {8'd0, leftOut}, 32'd0);
    check("R11", {8'd0, rightOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int f = 0; f < 4; f++) begin
      ctrlByte = {6'b101101, f[1:0]};
      #1;
      check("R9", {30'd0, fmtOut}, f);
    end
    @(negedge clk);

    // early strobes: zero delay passes, long delay reads unwritten slots as zero
    doSample(24'h111111, 24'hAAAAAA, 8'h00, 13'd0, 13'd3, "R2");
    doSample(24'h222222, 24'hBBBBBB, 8'h00, 13'd0, 13'd3, "R2");
    doSample(24'h333333, 24'hCCCCCC, 8'h3C, 13'd8191, 13'd3, "R2");
    doSample(24'h444444, 24'hDDDDDD, 8'h00, 13'd1, 13'd3, "R2");
    idleCheck();

    // independent channel delays
    for (int i = 0; i < 40; i++)
      doSample(24'($urandom), 24'($urandom), 8'h00, 13'd7, 13'd30, "R4");

    // random delays changing every strobe, random control
    for (int i = 0; i < 400; i++) begin
      logic [7:0] c;
      c = 8'($urandom);
      if (c[1:0] == 2'b11 && ($urandom % 4) != 0) c[1:0] = 2'b00;
      if (($urandom % 3) != 0) c[7:6] = 2'b00;
      doSample(24'($urandom), 24'($urandom), c, 13'($urandom % 64), 13'($urandom % 64), "R10");
      if (($urandom % 10) == 0) idleCheck();
    end

    // muted left keeps recording; unmuted outputs show samples taken while muted
    for (int i = 0; i < 6; i++)
      doSample(24'h500000 + 24'(i), 24'h600000 + 24'(i), 8'h40, 13'd3, 13'd2, "R7");
    for (int i = 0; i < 4; i++)
      doSample(24'($urandom), 24'($urandom), 8'h00, 13'd3, 13'd2, "R7");
    for (int i = 0; i < 4; i++)
      doSample(24'($urandom), 24'($urandom), 8'h80, 13'd2, 13'd2, "R7");
    for (int i = 0; i < 3; i++)
      doSample(24'($urandom), 24'($urandom), 8'hC0, 13'd2, 13'd2, "R7");
    for (int i = 0; i < 3; i++)
      doSample(24'($urandom), 24'($urandom), 8'h00, 13'd4, 13'd5, "R7");

    // bypass overrides programmed delays, mute still applies
    for (int i = 0; i < 5; i++)
      doSample(24'($urandom), 24'($urandom), 8'h03, 13'd100, 13'd8191, "R8");
    doSample(24'($urandom), 24'($urandom), 8'h83, 13'd100, 13'd5, "R8");
    doSample(24'($urandom), 24'($urandom), 8'h00, 13'd6, 13'd6, "R2");

    // maximum delay across buffer wrap
    while (n < 8450)
      doSample(24'($urandom), 24'($urandom), 8'h00, 13'd8191, 13'd5000, "R12");
    for (int i = 0; i < 30; i++)
      doSample(24'($urandom), 24'($urandom), 8'h00, 13'($urandom), 13'($urandom), "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule